// File: doc/BRIEF.md
# Zero-Operand Stack Arithmetic Unit

This block is a small evaluation stack held in registers. It carries out arithmetic commands that name no operands. A command carries one opcode, and for a push it also carries one data word. A push puts the word on the stack. A pop takes the newest entry off and returns it. The add, subtract, multiply and divide commands each consume the two newest entries and leave a single result in their place. Values are two's complement. When a binary command runs, the newest entry is the left operand and the entry beneath it is the right operand.

Commands enter through a valid/ready handshake. Every command that is taken produces a one-cycle completion pulse with a status code, and where the command yields a value, that value appears on a result output. Every command except divide completes in one cycle. Divide uses an iterative restoring divider, and the command port stays closed while the divider runs. A depth output always shows how many entries the stack holds.

Top module: `stack_alu`

## Requirements
- R1: After reset, depth is 0, `done` is low and `cmd_ready` is high.
- R2: Opcode 0 (push) puts `cmd_data` on top of the stack and raises depth by one. Opcode 1 (pop) removes the newest entry, returns it on `result` with `done`, and lowers depth by one. Values come back in last-in, first-out order.
- R3: A pop on an empty stack completes with status 1 (underflow), and depth stays 0.
- R4: A push while depth equals DEPTH completes with status 2 (overflow), and the stack contents and depth stay as they were.
- R5: Opcodes 2 (add), 3 (subtract) and 4 (multiply) replace the two newest entries with top+below, top−below and the low WIDTH bits of top×below, so depth falls by one. The new top is returned on `result`.
- R6: Any of opcodes 2 to 5 with fewer than two entries completes with status 1 (underflow), and the stack stays unchanged.
- R7: Opcode 5 (divide) replaces the two newest entries with the signed quotient top÷below, truncated toward zero. `cmd_ready` stays low for at least WIDTH cycles while the divider runs, depth does not change during that time, and `done` is not raised during that time.
- R8: A divide whose below entry is zero completes with status 3 (divide by zero) one cycle after acceptance, and both operands remain on the stack.
- R9: Every command other than a valid divide raises `done` for exactly one cycle, on the cycle after it is accepted. Status 0 means success.
- R10: Opcodes 6 and 7 complete with status 0 and leave the stack unchanged.
- R11: `depth` always equals the number of entries held and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Opcode: 0 push, 1 pop, 2 add, 3 sub, 4 mul, 5 div, 6/7 no-op |
| cmd_data | input | WIDTH | Value for a push |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Status with done: 0 ok, 1 underflow, 2 overflow, 3 divide by zero |
| result | output | WIDTH | Popped value or new top; 0 on error |
| depth | output | $clog2(DEPTH+1) | Current entry count |

## Verification
If the entry count is wrong, it shows at once on `depth` and on the status of the next boundary command. A push that goes missing or an operand order that is swapped shows on `result` as soon as the affected value is popped or combined, usually within a few commands. A wrong value left behind by a rejected command only shows when the stack is drained, so every error scenario ends by popping the entries it left and comparing them. A divider that misreports its iteration count shows in the number of cycles `cmd_ready` stays low, and a wrong sign or rounding rule shows on the quotient of operands with mixed signs.

// File: rtl/stack_alu_pkg.sv
package stack_alu_pkg;
   typedef enum logic [2:0] {
      OP_PUSH = 3'd0,
      OP_POP  = 3'd1,
      OP_ADD  = 3'd2,
      OP_SUB  = 3'd3,
      OP_MUL  = 3'd4,
      OP_DIV  = 3'd5,
      OP_NOP6 = 3'd6,
      OP_NOP7 = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      ST_OK    = 2'd0,
      ST_UNDER = 2'd1,
      ST_OVER  = 2'd2,
      ST_DIVZ  = 2'd3
   } status_e;
endpackage

// File: rtl/stack_store.sv
module stack_store #(
   parameter int W     = 16,
   parameter int DEPTH = 8,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          do_push,
   input  logic          do_pop,
   input  logic          do_fold,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  top,
   output logic [W-1:0]  nxt,
   output logic [CW-1:0] count
);
   logic [W-1:0] slot [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if ((do_push && count == CW'(i)) || (do_fold && count == CW'(i + 2)))
               slot[i] <= din;
         end
         if (do_push)
            count <= count + 1'b1;
         else if (do_pop || do_fold)
            count <= count - 1'b1;
      end
   end

   always_comb begin
      top = '0;
      nxt = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (count == CW'(i + 1)) top = slot[i];
         if (count == CW'(i + 2)) nxt = slot[i];
      end
   end
endmodule

// File: rtl/stack_arith.sv
module stack_arith
   import stack_alu_pkg::*;
#(
   parameter int W = 16
) (
   input  op_e          op,
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   output logic [W-1:0] y
);
   logic [W-1:0] prod;
   assign prod = lhs * rhs;

   always_comb begin
      unique case (op)
         OP_ADD:  y = lhs + rhs;
         OP_SUB:  y = lhs - rhs;
         OP_MUL:  y = prod;
         default: y = lhs;
      endcase
   end
endmodule

// File: rtl/stack_div.sv
module stack_div #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         busy,
   output logic         fin,
   output logic [W-1:0] quot
);
   localparam int IW = $clog2(W + 1);

   logic [W-1:0]  rem_q, quo_q, den_q;
   logic          neg_q;
   logic [IW-1:0] left_q;
   logic [W:0]    shifted, diff;
   logic [W-1:0]  num_mag, den_mag;

   assign num_mag = num[W-1] ? (~num + 1'b1) : num;
   assign den_mag = den[W-1] ? (~den + 1'b1) : den;
   assign shifted = {rem_q, quo_q[W-1]};
   assign diff    = shifted - {1'b0, den_q};
   assign quot    = neg_q ? (~quo_q + 1'b1) : quo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         den_q  <= '0;
         neg_q  <= 1'b0;
         left_q <= '0;
         busy   <= 1'b0;
         fin    <= 1'b0;
      end else if (start) begin
         rem_q  <= '0;
         quo_q  <= num_mag;
         den_q  <= den_mag;
         neg_q  <= num[W-1] ^ den[W-1];
         left_q <= IW'(W);
         busy   <= 1'b1;
         fin    <= 1'b0;
      end else if (busy) begin
         rem_q  <= diff[W] ? shifted[W-1:0] : diff[W-1:0];
         quo_q  <= {quo_q[W-2:0], ~diff[W]};
         left_q <= left_q - 1'b1;
         if (left_q == IW'(1)) begin
            busy <= 1'b0;
            fin  <= 1'b1;
         end
      end else begin
         fin <= 1'b0;
      end
   end
endmodule

// File: rtl/stack_alu.sv
module stack_alu
   import stack_alu_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [2:0]       cmd_op,
   input  logic [WIDTH-1:0] cmd_data,
   output logic             done,
   output logic [1:0]       err,
   output logic [WIDTH-1:0] result,
   output logic [CW-1:0]    depth
);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("stack_alu: DEPTH must be at least 2");
      end
      if (WIDTH < 2) begin : g_bad_width
         $error("stack_alu: WIDTH must be at least 2");
      end
   endgenerate

   op_e              op;
   logic             accept, div_run;
   logic [WIDTH-1:0] top, nxt, arith_y, quot;
   logic [CW-1:0]    count;
   logic             has1, has2;
   logic             do_push, do_pop, do_fold_cmd, div_start;
   logic             div_busy, div_fin;
   logic             fin_now;
   status_e          st_d;
   logic [WIDTH-1:0] res_d;
   logic [WIDTH-1:0] store_din;

   assign op        = op_e'(cmd_op);
   assign cmd_ready = ~div_run;
   assign accept    = cmd_valid & ~div_run;
   assign has1      = count != '0;
   assign has2      = count > CW'(1);
   assign depth     = count;

   stack_arith #(.W(WIDTH)) u_arith (
      .op  (op),
      .lhs (top),
      .rhs (nxt),
      .y   (arith_y)
   );

   always_comb begin
      do_push     = 1'b0;
      do_pop      = 1'b0;
      do_fold_cmd = 1'b0;
      div_start   = 1'b0;
      fin_now     = accept;
      st_d        = ST_OK;
      res_d       = '0;
      unique case (op)
         OP_PUSH: begin
            if (count == FULL) st_d = ST_OVER;
            else begin
               do_push = accept;
               res_d   = cmd_data;
            end
         end
         OP_POP: begin
            if (!has1) st_d = ST_UNDER;
            else begin
               do_pop = accept;
               res_d  = top;
            end
         end
         OP_ADD, OP_SUB, OP_MUL: begin
            if (!has2) st_d = ST_UNDER;
            else begin
               do_fold_cmd = accept;
               res_d       = arith_y;
            end
         end
         OP_DIV: begin
            if (!has2) st_d = ST_UNDER;
            else if (nxt == '0) st_d = ST_DIVZ;
            else begin
               div_start = accept;
               fin_now   = 1'b0;
            end
         end
         default: ;
      endcase
   end

   assign store_din = div_fin ? quot : (do_push ? cmd_data : arith_y);

   stack_store #(.W(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .do_push (do_push),
      .do_pop  (do_pop),
      .do_fold (do_fold_cmd | div_fin),
      .din     (store_din),
      .top     (top),
      .nxt     (nxt),
      .count   (count)
   );

   stack_div #(.W(WIDTH)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_start),
      .num   (top),
      .den   (nxt),
      .busy  (div_busy),
      .fin   (div_fin),
      .quot  (quot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_run <= 1'b0;
         done    <= 1'b0;
         err     <= ST_OK;
         result  <= '0;
      end else begin
         if (div_start) div_run <= 1'b1;
         else if (div_fin) div_run <= 1'b0;
         if (div_fin) begin
            done   <= 1'b1;
            err    <= ST_OK;
            result <= quot;
         end else if (fin_now) begin
            done   <= 1'b1;
            err    <= st_d;
            result <= res_d;
         end else begin
            done   <= 1'b0;
            err    <= ST_OK;
            result <= '0;
         end
      end
   end

   logic unused_busy;
   assign unused_busy = div_busy;
endmodule

// File: rtl/stack_alu_chk.sv
module stack_alu_chk #(
   parameter int DEPTH = 8,
   parameter int CW    = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          cmd_ready,
   input logic [2:0]    cmd_op,
   input logic          done,
   input logic [1:0]    err,
   input logic [CW-1:0] depth
);
   logic acc;
   assign acc = cmd_valid & cmd_ready;

   AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= CW'(DEPTH)); // R11

   AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd0 && depth < CW'(DEPTH)) |=>
      (done && err == 2'd0 && depth == $past(depth) + 1'b1)); // R2

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd0 && depth == CW'(DEPTH)) |=>
      (done && err == 2'd2 && depth == $past(depth))); // R4

   AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd1 && depth == '0) |=>
      (done && err == 2'd1 && depth == '0)); // R3

   AST_BIN_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op >= 3'd2 && cmd_op <= 3'd5 && depth < CW'(2)) |=>
      (done && err == 2'd1 && depth == $past(depth))); // R6

   AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready |-> (!done && $stable(depth))); // R7

   AST_RSV_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op >= 3'd6) |=>
      (done && err == 2'd0 && depth == $past(depth))); // R10
endmodule

bind stack_alu stack_alu_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .done      (done),
   .err       (err),
   .depth     (depth)
);

// File: tb/tb_stack_alu.sv
`timescale 1ns/1ps
module tb_stack_alu;
   localparam int W = 16;
   localparam int D = 8;
   localparam int CW = $clog2(D + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [2:0]    cmd_op = '0;
   logic [W-1:0]  cmd_data = '0;
   logic          done;
   logic [1:0]    err;
   logic [W-1:0]  result;
   logic [CW-1:0] depth;

   int n_run = 0;
   int n_fail = 0;
   logic         r_done;
   int           r_err, r_res, r_depth, r_lat, r_low;

   always #5 clk = ~clk;

   stack_alu #(.WIDTH(W), .DEPTH(D)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_data(cmd_data), .done(done), .err(err),
      .result(result), .depth(depth)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic send(input logic [2:0] op, input int val);
      int n;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_data  = W'(val);
      @(negedge clk);
      cmd_valid = 1'b0;
      n = 1;
      r_low = 0;
      while (!done && n < 100) begin
         if (!cmd_ready) r_low++;
         @(negedge clk);
         n++;
      end
      r_done  = done;
      r_err   = int'(err);
      r_res   = int'($signed(result));
      r_depth = int'(depth);
      r_lat   = n;
   endtask

   task automatic drain();
      while (depth != 0) send(3'd1, 0);
   endtask

   task automatic t_reset();
      chk("R1 depth", int'(depth), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 ready", int'(cmd_ready), 1);
   endtask

   task automatic t_lifo();
      send(3'd0, 5);   chk("R9 push latency", r_lat, 1);
      chk("R9 push status", r_err, 0);
      @(negedge clk);  chk("R9 done one cycle", int'(done), 0);
      send(3'd0, -7);
      send(3'd0, 9);   chk("R11 depth after pushes", r_depth, 3);
      send(3'd1, 0);   chk("R2 pop first", r_res, 9);
      send(3'd1, 0);   chk("R2 pop second", r_res, -7);
      send(3'd1, 0);   chk("R2 pop third", r_res, 5);
      chk("R2 depth empty", r_depth, 0);
   endtask

   task automatic t_pop_empty();
      send(3'd1, 0);
      chk("R3 status", r_err, 1);
      chk("R3 depth", r_depth, 0);
   endtask

   task automatic t_overflow();
      for (int i = 0; i < D; i++) send(3'd0, 100 + i);
      chk("R11 depth full", r_depth, D);
      send(3'd0, 555);
      chk("R4 status", r_err, 2);
      chk("R4 depth", r_depth, D);
      send(3'd1, 0);
      chk("R4 top kept", r_res, 100 + D - 1);
      drain();
   endtask

   task automatic t_arith();
      send(3'd0, 3); send(3'd0, 10); send(3'd3, 0);
      chk("R5 sub top-below", r_res, 7);
      chk("R5 sub depth", r_depth, 1);
      send(3'd0, 4); send(3'd0, -6); send(3'd2, 0);
      chk("R5 add", r_res, -2);
      send(3'd0, 300); send(3'd0, 300); send(3'd4, 0);
      chk("R5 mul low bits", r_res, 24464);
      send(3'd1, 0); chk("R5 after mul", r_res, 24464);
      send(3'd1, 0); chk("R5 add kept", r_res, -2);
      send(3'd1, 0); chk("R5 sub kept", r_res, 7);
   endtask

   task automatic t_bin_under();
      send(3'd2, 0);
      chk("R6 add empty", r_err, 1);
      send(3'd0, 1); send(3'd4, 0);
      chk("R6 mul one entry", r_err, 1);
      chk("R6 depth", r_depth, 1);
      send(3'd5, 0);
      chk("R6 div one entry", r_err, 1);
      send(3'd1, 0); chk("R6 entry kept", r_res, 1);
   endtask

   task automatic t_div();
      send(3'd0, 7); send(3'd0, -45); send(3'd5, 0);
      chk("R7 neg quotient", r_res, -6);
      chk("R7 status", r_err, 0);
      chk("R7 depth", r_depth, 1);
      chk("R7 ready low cycles", int'(r_low >= W), 1);
      send(3'd0, -3); send(3'd0, 20); send(3'd5, 0);
      chk("R7 neg divisor", r_res, -6);
      send(3'd0, 5); send(3'd0, 100); send(3'd5, 0);
      chk("R7 positive", r_res, 20);
      send(3'd0, -4); send(3'd0, -9); send(3'd5, 0);
      chk("R7 both negative", r_res, 2);
      drain();
   endtask

   task automatic t_divzero();
      send(3'd0, 0); send(3'd0, 9); send(3'd5, 0);
      chk("R8 status", r_err, 3);
      chk("R8 latency", r_lat, 1);
      chk("R8 depth", r_depth, 2);
      send(3'd1, 0); chk("R8 top kept", r_res, 9);
      send(3'd1, 0); chk("R8 below kept", r_res, 0);
   endtask

   task automatic t_reserved();
      send(3'd0, 11);
      send(3'd6, 0); chk("R10 op6 status", r_err, 0);
      chk("R10 op6 depth", r_depth, 1);
      send(3'd7, 0); chk("R10 op7 done", int'(r_done), 1);
      send(3'd1, 0); chk("R10 value kept", r_res, 11);
   endtask

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lifo();
      t_pop_empty();
      t_overflow();
      t_arith();
      t_bin_under();
      t_div();
      t_divzero();
      t_reserved();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule